// File: doc/BRIEF.md
# UART Command Frame Bridge

This block turns a byte stream arriving from a UART receiver into accesses on a simple register bus, and returns answer bytes through a UART transmitter. Bit timing and baud generation sit outside the block: both directions are byte-wide valid/ready handshakes. Every command is a fixed five-byte frame, most significant byte first, forming a 40-bit word. The top nibble holds the opcode and the low 32 bits hold the payload.

A bus write takes two frames. A data-load frame first fills an internal 32-bit data latch. An access frame then names the address and the direction. A read stores the bus result in that same latch, and a separate fetch frame sends the latch back as four bytes. A host that has lost its place in the byte stream sends a single zero byte. The block answers it with a fixed four-byte magic word, so the host can line up on frame boundaries again. A partial frame left idle for too long is dropped.

The command sequencer has these states and transitions. ST_IDLE moves to ST_DECODE when a frame completes. ST_DECODE moves to ST_WRITE for a bus write, to ST_READ for a bus read, and to ST_REPLY for a sync or a fetch. It returns straight to ST_IDLE for a data load, an auxiliary load or an unknown opcode. ST_WRITE and ST_READ return to ST_IDLE after one cycle. ST_REPLY moves to ST_DRAIN after one cycle, and ST_DRAIN returns to ST_IDLE once the last reply byte has been taken.

Top module: `uart_cmd_bridge`

## Requirements
- R1: A frame is five accepted bytes, first byte most significant. Frame bits 39:36 are the opcode: 0 sync, 1 register access, 2 data load, 3 data fetch, 4 auxiliary load. Bits 31:0 are the payload. Bits 35:32 are ignored.
- R2: A sync command sends the bytes 0xCA, 0xFE, 0xBA, 0xBE, in that order.
- R3: A zero byte accepted as the first byte of a frame is taken at once as a sync, and the frame count stays at zero. Zero bytes in positions two to five are ordinary frame content.
- R4: A data load (opcode 2) copies payload bits 31:0 into the data latch and causes no bus strobe and no reply.
- R5: A register access with bit 20 clear gives exactly one cycle of bus_we. In that cycle bus_addr equals frame bits 19:0 and bus_wdata equals the data latch.
- R6: A register access with bit 20 set gives exactly one cycle of bus_re at address bits 19:0. bus_rdata is sampled in that cycle and stored in the data latch.
- R7: A data fetch (opcode 3) sends the data latch as four bytes, most significant byte first.
- R8: An auxiliary load (opcode 4) copies payload bits 31:0 to aux_ctrl, which otherwise holds its value.
- R9: Opcodes 5 to 15 cause no bus strobe and no reply, and leave the data latch and aux_ctrl unchanged.
- R10: If a partial frame receives no byte for TMO_CYCLES cycles, it is discarded, and the next byte starts a new frame.
- R11: rx_ready is low from the cycle after a frame's last byte until the command finishes, which for a reply means until its last byte is accepted.
- R12: After reset, aux_ctrl and the data latch are 0, tx_valid, bus_we and bus_re are low, and rx_ready is high.
- R13: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte present |
| rx_ready | output | 1 | Block can take a byte |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply byte present |
| tx_ready | input | 1 | Transmitter takes the byte |
| bus_addr | output | ADDR_W (20) | Register bus address |
| bus_wdata | output | 32 | Register bus write data (data latch) |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read strobe |
| bus_rdata | input | 32 | Read data, valid in the bus_re cycle |
| aux_ctrl | output | 32 | Auxiliary control word |

## Verification
Call E the clock edge that accepts a frame's last byte. The frame appears at the sequencer one edge after E. A bus strobe is high between E+2 and E+3. The first reply byte is offered from E+3, and with tx_ready held high the four bytes are taken at E+4 through E+7. The bench therefore waits a fixed window of 20 cycles after each frame. It samples strobes, reply bytes and outputs on falling edges, and compares counts and values only once the window has closed. The back-pressure test instead samples at points chosen to fall while the reply is still stalled.

// File: rtl/ucb_pkg.sv
package ucb_pkg;

    localparam int BYTE_W   = 8;
    localparam int DATA_W   = 32;
    localparam int FRAME_B  = 5;
    localparam int REPLY_B  = DATA_W / BYTE_W;
    localparam int RD_BIT   = 20;

    localparam logic [3:0] OP_SYNC  = 4'd0;
    localparam logic [3:0] OP_ACC   = 4'd1;
    localparam logic [3:0] OP_LOAD  = 4'd2;
    localparam logic [3:0] OP_FETCH = 4'd3;
    localparam logic [3:0] OP_AUX   = 4'd4;

    localparam logic [DATA_W-1:0] MAGIC_WORD = 32'hCAFE_BABE;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_WRITE,
        ST_READ,
        ST_REPLY,
        ST_DRAIN
    } ucb_state_e;

endpackage

// File: rtl/ucb_frame_asm.sv
module ucb_frame_asm #(
    parameter int TMO_CYCLES = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take_en,
    input  logic [7:0]  rx_data,
    input  logic        rx_valid,
    output logic        frm_valid,
    output logic [3:0]  frm_op,
    output logic [31:0] frm_pay
);
    import ucb_pkg::*;

    localparam int CNT_W = $clog2(FRAME_B);
    localparam int TMO_W = $clog2(TMO_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_B - 1);
    localparam logic [TMO_W-1:0] TMO_LIM  = TMO_W'(TMO_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [TMO_W-1:0] tmo_q;
    logic [3:0]       op_q;
    logic [23:0]      pay_sh_q;
    logic             accept;

    assign accept = rx_valid && take_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            tmo_q     <= '0;
            op_q      <= '0;
            pay_sh_q  <= '0;
            frm_valid <= 1'b0;
            frm_op    <= '0;
            frm_pay   <= '0;
        end else begin
            frm_valid <= 1'b0;
            if (accept) begin
                tmo_q <= '0;
                if (cnt_q == '0 && rx_data == 8'h00) begin
                    frm_valid <= 1'b1;
                    frm_op    <= OP_SYNC;
                    frm_pay   <= '0;
                end else if (cnt_q == '0) begin
                    op_q  <= rx_data[7:4];
                    cnt_q <= cnt_q + 1'b1;
                end else if (cnt_q == LAST_IDX) begin
                    frm_valid <= 1'b1;
                    frm_op    <= op_q;
                    frm_pay   <= {pay_sh_q, rx_data};
                    cnt_q     <= '0;
                end else begin
                    pay_sh_q <= {pay_sh_q[15:0], rx_data};
                    cnt_q    <= cnt_q + 1'b1;
                end
            end else if (cnt_q != '0) begin
                if (tmo_q == TMO_LIM) begin
                    cnt_q <= '0;
                    tmo_q <= '0;
                end else begin
                    tmo_q <= tmo_q + 1'b1;
                end
            end else begin
                tmo_q <= '0;
            end
        end
    end

    a_r1_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);

    a_r3_lone_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cnt_q == '0 && rx_data == 8'h00) |=>
        (frm_valid && frm_op == OP_SYNC && cnt_q == '0));

    a_r10_stale_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && cnt_q != '0 && tmo_q == TMO_LIM) |=> (cnt_q == '0));

endmodule

// File: rtl/ucb_reply_ser.sv
module ucb_reply_ser #(
    parameter int NBYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [NBYTES*8-1:0]   word,
    output logic                  busy,
    output logic [7:0]            tx_data,
    input  logic                  tx_ready,
    output logic                  tx_valid
);
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

    logic [NBYTES*8-1:0] word_q;
    logic [IDX_W-1:0]    idx_q;

    assign tx_valid = busy;
    assign tx_data  = word_q[NBYTES*8-1 -: 8];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
            busy   <= 1'b0;
        end else if (start && !busy) begin
            word_q <= word;
            idx_q  <= '0;
            busy   <= 1'b1;
        end else if (busy && tx_ready) begin
            word_q <= word_q << 8;
            idx_q  <= idx_q + 1'b1;
            if (idx_q == LAST) begin
                busy <= 1'b0;
            end
        end
    end

    a_r13_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: rtl/uart_cmd_bridge.sv
module uart_cmd_bridge #(
    parameter int ADDR_W     = 20,
    parameter int TMO_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    input  logic [31:0]       bus_rdata,
    output logic [31:0]       aux_ctrl
);
    import ucb_pkg::*;

    ucb_state_e          state_q;
    ucb_state_e          state_d;
    logic                frm_valid;
    logic [3:0]          frm_op;
    logic [31:0]         frm_pay;
    logic [3:0]          op_q;
    logic [31:0]         pay_q;
    logic [DATA_W-1:0]   latch_q;
    logic [DATA_W-1:0]   reply_q;
    logic                ser_start;
    logic                ser_busy;

    ucb_frame_asm #(
        .TMO_CYCLES (TMO_CYCLES)
    ) asm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_en   (rx_ready),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .frm_valid (frm_valid),
        .frm_op    (frm_op),
        .frm_pay   (frm_pay)
    );

    ucb_reply_ser #(
        .NBYTES (REPLY_B)
    ) ser_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (ser_start),
        .word     (reply_q),
        .busy     (ser_busy),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (frm_valid) state_d = ST_DECODE;
            ST_DECODE: begin
                unique case (op_q)
                    OP_SYNC, OP_FETCH: state_d = ST_REPLY;
                    OP_ACC:            state_d = pay_q[RD_BIT] ? ST_READ : ST_WRITE;
                    default:           state_d = ST_IDLE;
                endcase
            end
            ST_WRITE:  state_d = ST_IDLE;
            ST_READ:   state_d = ST_IDLE;
            ST_REPLY:  state_d = ST_DRAIN;
            ST_DRAIN:  if (!ser_busy) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        rx_ready  = (state_q == ST_IDLE) && !frm_valid;
        bus_we    = (state_q == ST_WRITE);
        bus_re    = (state_q == ST_READ);
        ser_start = (state_q == ST_REPLY);
        bus_addr  = pay_q[ADDR_W-1:0];
        bus_wdata = latch_q;
    end

    // command and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            pay_q    <= '0;
            latch_q  <= '0;
            reply_q  <= '0;
            aux_ctrl <= '0;
        end else begin
            if (state_q == ST_IDLE && frm_valid) begin
                op_q  <= frm_op;
                pay_q <= frm_pay;
            end
            if (state_q == ST_DECODE) begin
                unique case (op_q)
                    OP_SYNC:  reply_q  <= MAGIC_WORD;
                    OP_FETCH: reply_q  <= latch_q;
                    OP_LOAD:  latch_q  <= pay_q;
                    OP_AUX:   aux_ctrl <= pay_q;
                    default:  ;
                endcase
            end
            if (state_q == ST_READ) begin
                latch_q <= bus_rdata;
            end
        end
    end

    a_r5_we_follows_decode: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> ($past(state_q) == ST_DECODE && !bus_re));

    a_r6_read_captured: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> (latch_q == $past(bus_rdata)));

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re |=> !bus_re);

    a_r11_no_take_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !rx_ready);

    a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && op_q > OP_AUX) |=>
        (state_q == ST_IDLE && !bus_we && !bus_re && !tx_valid));

endmodule

// File: tb/uart_cmd_bridge_tb_top.sv
`timescale 1ns/1ps
module uart_cmd_bridge_tb_top;

    localparam int TMO = 40;
    localparam int NV  = 11;
    localparam logic [2:0] K_NONE = 3'd0, K_WR = 3'd1, K_RD = 3'd2,
                           K_REP = 3'd3, K_AUX = 3'd4;

    // {frame, kind, expected value, expected address}
    localparam logic [94:0] VEC [NV] = '{
        {40'h01_0000_0000, K_REP,  32'hCAFEBABE, 20'h0},      // R1 R2 full sync frame
        {40'h20_DEAD_BEEF, K_NONE, 32'h0,        20'h0},      // R4 load
        {40'h30_0000_0000, K_REP,  32'hDEADBEEF, 20'h0},      // R7 fetch, R3 inner zeros
        {40'h10_0001_2345, K_WR,   32'hDEADBEEF, 20'h12345},  // R5 write
        {40'h10_0010_0ABC, K_RD,   32'h0,        20'h00ABC},  // R6 read
        {40'h30_0000_0000, K_REP,  32'hA5C00ABC, 20'h0},      // R6 latch readback
        {40'h4F_1234_5678, K_AUX,  32'h12345678, 20'h0},      // R8 aux, R1 bits 35:32 ignored
        {40'h70_1122_3344, K_NONE, 32'h0,        20'h0},      // R9 unknown
        {40'hF0_FFFF_FFFF, K_AUX,  32'h12345678, 20'h0},      // R9 unknown, aux kept
        {40'h30_0000_0000, K_REP,  32'hA5C00ABC, 20'h0},      // R9 latch kept
        {40'h10_000F_FFFF, K_WR,   32'hA5C00ABC, 20'hFFFFF}   // R5 top address
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [19:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic        bus_re;
    logic [31:0] bus_rdata;
    logic [31:0] aux_ctrl;

    int checks = 0;
    int errors = 0;
    int we_cnt = 0;
    int re_cnt = 0;
    int rep_n  = 0;
    logic [7:0]  rep [16];
    logic [19:0] last_waddr, last_raddr;
    logic [31:0] last_wdata;

    always #4 clk = ~clk;

    assign bus_rdata = {12'hA5C, bus_addr};

    uart_cmd_bridge #(
        .ADDR_W     (20),
        .TMO_CYCLES (TMO)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .aux_ctrl  (aux_ctrl)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_we) begin
                we_cnt++;
                last_waddr = bus_addr;
                last_wdata = bus_wdata;
            end
            if (bus_re) begin
                re_cnt++;
                last_raddr = bus_addr;
            end
            if (tx_valid && tx_ready) begin
                if (rep_n < 16) rep[rep_n] = tx_data;
                rep_n++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk); #1;
        rx_data  = b;
        rx_valid = 1'b1;
        do @(negedge clk); while (!rx_ready);
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [39:0] f);
        for (int i = 4; i >= 0; i--) send_byte(f[i*8 +: 8]);
    endtask

    function automatic logic [31:0] rep_word();
        return {rep[0], rep[1], rep[2], rep[3]};
    endfunction

    function automatic string tag_of(input logic [2:0] k);
        case (k)
            K_WR:  return "R5";
            K_RD:  return "R6";
            K_REP: return "R2/R7";
            K_AUX: return "R8";
            default: return "R4/R9";
        endcase
    endfunction

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(aux_ctrl == 0, "R12 aux", aux_ctrl, 0);
        check(!tx_valid && !bus_we && !bus_re, "R12 idle outputs",
              {tx_valid, bus_we, bus_re}, 0);
        check(rx_ready, "R12 rx_ready", rx_ready, 1);
        rep_n = 0;
        send_frame(40'h30_0000_0000);
        repeat (20) @(negedge clk);
        check(rep_n == 4 && rep_word() == 0, "R12 latch reset", rep_word(), 0);

        // R3 lone zero byte answers sync immediately
        rep_n = 0;
        send_byte(8'h00);
        repeat (20) @(negedge clk);
        check(rep_n == 4, "R3 lone zero reply count", rep_n, 4);
        check(rep_word() == 32'hCAFEBABE, "R2 magic order", rep_word(), 32'hCAFEBABE);

        // table of frames
        for (int v = 0; v < NV; v++) begin
            automatic logic [39:0] f  = VEC[v][94:55];
            automatic logic [2:0]  k  = VEC[v][54:52];
            automatic logic [31:0] ev = VEC[v][51:20];
            automatic logic [19:0] ea = VEC[v][19:0];
            automatic int we0 = we_cnt;
            automatic int re0 = re_cnt;
            rep_n = 0;
            send_frame(f);
            repeat (20) @(negedge clk);
            check(we_cnt - we0 == ((k == K_WR) ? 1 : 0), tag_of(k), we_cnt - we0, k == K_WR);
            check(re_cnt - re0 == ((k == K_RD) ? 1 : 0), tag_of(k), re_cnt - re0, k == K_RD);
            check(rep_n == ((k == K_REP) ? 4 : 0), tag_of(k), rep_n, (k == K_REP) ? 4 : 0);
            if (k == K_REP) check(rep_word() == ev, tag_of(k), rep_word(), ev);
            if (k == K_WR) begin
                check(last_waddr == ea, "R5 addr", last_waddr, ea);
                check(last_wdata == ev, "R5 data", last_wdata, ev);
            end
            if (k == K_RD)  check(last_raddr == ea, "R6 addr", last_raddr, ea);
            if (k == K_AUX) check(aux_ctrl == ev, tag_of(k), aux_ctrl, ev);
        end

        // R10 stale partial frame dropped
        send_frame(40'h20_1357_9BDF);
        repeat (5) @(negedge clk);
        send_byte(8'h20);
        send_byte(8'h11);
        repeat (TMO + 10) @(negedge clk);
        rep_n = 0;
        send_frame(40'h30_0000_0000);
        repeat (20) @(negedge clk);
        check(rep_n == 4, "R10 reply count", rep_n, 4);
        check(rep_word() == 32'h13579BDF, "R10 latch", rep_word(), 32'h13579BDF);

        // R11 / R13 back-pressure on the reply
        @(posedge clk); #1 tx_ready = 1'b0;
        rep_n = 0;
        send_frame(40'h30_0000_0000);
        repeat (12) @(negedge clk);
        check(!rx_ready, "R11 rx blocked", rx_ready, 0);
        check(tx_valid && tx_data == 8'h13, "R13 first byte", tx_data, 8'h13);
        repeat (5) @(negedge clk);
        check(tx_valid && tx_data == 8'h13, "R13 held byte", tx_data, 8'h13);
        @(posedge clk); #1 tx_ready = 1'b1;
        repeat (20) @(negedge clk);
        check(rep_word() == 32'h13579BDF && rep_n == 4, "R11 drained", rep_word(), 32'h13579BDF);
        check(rx_ready, "R11 rx reopened", rx_ready, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule